// File: doc/BRIEF.md
# Lane Training-Set Receive Tracker and Transmit Field Patcher

This block is one lane's slice of a serial link's physical-layer MAC. It sits between the lane's 8b/10b PCS and the link training state machine. On the receive side it takes one decoded symbol per clock, with its control flag, and finds 16-symbol training sets. It tells the state machine whether each complete set was type one or type two. It also reports how many sets of that type have arrived back to back, and it flags sets that break the format.

On the transmit side it chooses, each cycle, between the data-link-layer symbol stream and the shared ordered-set generator. The generator produces the same training sets for every lane. This slice writes its own lane number into the lane field. When the state machine has disabled the lane, it forces PAD into both the link and the lane fields. SKP sets pass through untouched. The transmit output is registered and has one cycle of latency.

Top module: `lane_os_mac`

## Requirements
- R1: After synchronous reset, ts_done, ts_bad, ts_type, ts_count, tx_data and tx_ctrl are all zero.
- R2: A training set is 16 valid symbols that begin with COM (0xBC, control flag 1). The symbol at index 6 is 0x4A for type one (ts_type 1) or 0x45 for type two (ts_type 2). ts_done pulses for one cycle, and ts_type and ts_count update on the clock edge that samples index 15.
- R3: A completed set of the same type as the previous completed set increments ts_count by one.
- R4: A completed set whose type differs from the current ts_type, or that follows a count of zero, sets ts_count to 1.
- R5: ts_count saturates at 15 and holds there while same-type sets continue.
- R6: A set is malformed if a control symbol appears at index 3 to 15, a control symbol other than PAD appears at index 1 or 2, or index 6 holds neither identifier. A malformed set pulses ts_bad and clears ts_type and ts_count to zero. If the offending symbol is COM, a new set starts there.
- R7: PAD (0xF7, control flag 1) is accepted in the link field (index 1) and the lane field (index 2) of a received set.
- R8: While rx_valid is low the symbol is ignored and the position within the set is kept.
- R9: With tx_sel_os low, tx_data and tx_ctrl equal the data-link-layer symbol from one cycle earlier.
- R10: With tx_sel_os high, the generator symbol is forwarded one cycle later. In a training set, index 2 is replaced by lane_num as data (control flag 0), and all other indices pass unchanged.
- R11: With tx_lane_off high, the link field and the lane field of a transmitted training set are both replaced by PAD (0xF7, control flag 1).
- R12: A generator set whose symbol after COM is SKP (0x1C, control flag 1) is forwarded unaltered at every index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received symbol is valid this cycle |
| rx_data | input | 8 | Received decoded symbol |
| rx_ctrl | input | 1 | Received symbol is a control symbol |
| ts_done | output | 1 | One-cycle pulse when a training set completes |
| ts_bad | output | 1 | One-cycle pulse on a malformed set |
| ts_type | output | 2 | Last set type: 0 none, 1 type one, 2 type two |
| ts_count | output | 4 | Consecutive same-type sets, saturating |
| tx_sel_os | input | 1 | Registered select: 1 generator, 0 data link layer |
| tx_lane_off | input | 1 | Lane disabled by the training state machine |
| lane_num | input | 5 | This lane's number |
| os_data | input | 8 | Ordered-set generator symbol |
| os_ctrl | input | 1 | Ordered-set generator control flag |
| dll_data | input | 8 | Data-link-layer symbol |
| dll_ctrl | input | 1 | Data-link-layer control flag |
| tx_data | output | 8 | Transmit symbol to the PCS |
| tx_ctrl | output | 1 | Transmit control flag |

## Verification
Several rules are checked by assertions on every cycle. The counter must step by one on each same-type completion, hold at its ceiling, and clear on any malformed set. A completion and a format error never coincide. The data-link-layer path and SKP sets pass through with one cycle of delay, and a disabled lane always emits PAD in its lane field. Only the bench's scenarios can show the rest. That includes recognising each identifier in a full symbol stream and restarting on a COM in mid-set. It also covers holding position across invalid cycles and accepting PAD only in the two field slots. The last is the index-exact patching of the lane number.

// File: rtl/lane_os_pkg.sv
package lane_os_pkg;
  localparam logic [7:0] SYM_COM = 8'hBC;
  localparam logic [7:0] SYM_PAD = 8'hF7;
  localparam logic [7:0] SYM_SKP = 8'h1C;
  localparam logic [7:0] ID_ONE  = 8'h4A;
  localparam logic [7:0] ID_TWO  = 8'h45;

  localparam int LINK_POS = 1;
  localparam int LANE_POS = 2;
  localparam int ID_POS   = 6;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_ONE  = 2'd1,
    KIND_TWO  = 2'd2
  } ts_kind_e;
endpackage

// File: rtl/lm_rx_parse.sv
module lm_rx_parse
  import lane_os_pkg::*;
#(
  parameter int SET_LEN = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     valid_i,
  input  logic [7:0] data_i,
  input  logic     ctrl_i,
  output logic     done_o,
  output logic     bad_o,
  output ts_kind_e kind_o
);
  localparam int IW = $clog2(SET_LEN);
  localparam logic [IW-1:0] LAST = IW'(SET_LEN - 1);

  logic          active_q, active_d;
  logic [IW-1:0] pos_q, pos_d;
  ts_kind_e      kind_q, kind_d;
  logic          is_com, is_pad, field_slot, sym_ok;

  assign is_com     = ctrl_i && (data_i == SYM_COM);
  assign is_pad     = ctrl_i && (data_i == SYM_PAD);
  assign field_slot = (pos_q == IW'(LINK_POS)) || (pos_q == IW'(LANE_POS));

  always_comb begin
    active_d = active_q;
    pos_d    = pos_q;
    kind_d   = kind_q;
    done_o   = 1'b0;
    bad_o    = 1'b0;
    kind_o   = kind_q;
    sym_ok   = 1'b1;
    if (valid_i) begin
      if (!active_q) begin
        if (is_com) begin
          active_d = 1'b1;
          pos_d    = IW'(1);
        end
      end else begin
        if (ctrl_i && !(is_pad && field_slot)) sym_ok = 1'b0;
        if (pos_q == IW'(ID_POS)) begin
          if (ctrl_i)                 sym_ok = 1'b0;
          else if (data_i == ID_ONE)  kind_d = KIND_ONE;
          else if (data_i == ID_TWO)  kind_d = KIND_TWO;
          else                        sym_ok = 1'b0;
        end
        if (!sym_ok) begin
          bad_o    = 1'b1;
          active_d = is_com;
          pos_d    = IW'(1);
        end else if (pos_q == LAST) begin
          done_o   = 1'b1;
          active_d = 1'b0;
        end else begin
          pos_d = pos_q + IW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      pos_q    <= '0;
      kind_q   <= KIND_NONE;
    end else begin
      active_q <= active_d;
      pos_q    <= pos_d;
      kind_q   <= kind_d;
    end
  end

  // R6: a set cannot both complete and fail on the same symbol
  a_r6_done_not_bad: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !bad_o);
  // R8: with no valid symbol the parse position stays put
  a_r8_hold_pos: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(pos_q) && $stable(active_q));
endmodule

// File: rtl/lm_rx_count.sv
module lm_rx_count
  import lane_os_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done_i,
  input  logic             bad_i,
  input  ts_kind_e         kind_i,
  output logic             done_o,
  output logic             bad_o,
  output ts_kind_e         kind_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o <= 1'b0;
      bad_o  <= 1'b0;
      kind_o <= KIND_NONE;
      cnt_o  <= '0;
    end else begin
      done_o <= done_i;
      bad_o  <= bad_i;
      if (bad_i) begin
        kind_o <= KIND_NONE;
        cnt_o  <= '0;
      end else if (done_i) begin
        kind_o <= kind_i;
        if (kind_i == kind_o && cnt_o != '0)
          cnt_o <= (cnt_o == CNT_MAX) ? CNT_MAX : cnt_o + CNT_W'(1);
        else
          cnt_o <= CNT_W'(1);
      end
    end
  end

  // R3: same-type completion below the ceiling steps the count by one
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    done_i && !bad_i && kind_i == kind_o && cnt_o != '0 && cnt_o != CNT_MAX
      |=> cnt_o == $past(cnt_o) + CNT_W'(1));
  // R5: ceiling holds
  a_r5_saturate: assert property (@(posedge clk) disable iff (rst)
    done_i && !bad_i && kind_i == kind_o && cnt_o == CNT_MAX |=> cnt_o == CNT_MAX);
  // R6: malformed set clears the report
  a_r6_bad_clears: assert property (@(posedge clk) disable iff (rst)
    bad_i |=> cnt_o == '0 && kind_o == KIND_NONE && bad_o);
  // R2: a completion pulse always carries a typed, nonzero report
  a_r2_done_valid: assert property (@(posedge clk) disable iff (rst)
    done_o |-> cnt_o != '0 && kind_o != KIND_NONE);
endmodule

// File: rtl/lm_tx_patch.sv
module lm_tx_patch
  import lane_os_pkg::*;
#(
  parameter int SET_LEN = 16,
  parameter int LANE_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_os_i,
  input  logic              lane_off_i,
  input  logic [LANE_W-1:0] lane_num_i,
  input  logic [7:0]        os_data_i,
  input  logic              os_ctrl_i,
  input  logic [7:0]        dll_data_i,
  input  logic              dll_ctrl_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_ctrl_o
);
  localparam int PW = $clog2(SET_LEN);
  localparam logic [PW-1:0] POS_END = {PW{1'b1}};

  logic [PW-1:0] pos_q, pos_d, cur_pos;
  logic          ts_q, ts_d, ts_now;
  logic          os_com, os_skp;
  logic [7:0]    pat_data, nxt_data;
  logic          pat_ctrl, nxt_ctrl;

  assign os_com  = os_ctrl_i && (os_data_i == SYM_COM);
  assign os_skp  = os_ctrl_i && (os_data_i == SYM_SKP);
  assign cur_pos = os_com ? '0 : pos_q;
  assign pos_d   = os_com ? PW'(1) : ((pos_q == POS_END) ? POS_END : pos_q + PW'(1));

  always_comb begin
    if (cur_pos == PW'(LINK_POS)) begin
      ts_now = !os_skp;
      ts_d   = !os_skp;
    end else begin
      ts_now = ts_q;
      ts_d   = os_com ? 1'b0 : ts_q;
    end
  end

  always_comb begin
    pat_data = os_data_i;
    pat_ctrl = os_ctrl_i;
    if (ts_now && cur_pos == PW'(LINK_POS) && lane_off_i) begin
      pat_data = SYM_PAD;
      pat_ctrl = 1'b1;
    end else if (ts_now && cur_pos == PW'(LANE_POS)) begin
      if (lane_off_i) begin
        pat_data = SYM_PAD;
        pat_ctrl = 1'b1;
      end else begin
        pat_data = {{(8 - LANE_W){1'b0}}, lane_num_i};
        pat_ctrl = 1'b0;
      end
    end
    nxt_data = sel_os_i ? pat_data : dll_data_i;
    nxt_ctrl = sel_os_i ? pat_ctrl : dll_ctrl_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q     <= POS_END;
      ts_q      <= 1'b0;
      tx_data_o <= '0;
      tx_ctrl_o <= 1'b0;
    end else begin
      pos_q     <= pos_d;
      ts_q      <= ts_d;
      tx_data_o <= nxt_data;
      tx_ctrl_o <= nxt_ctrl;
    end
  end

  // R9: link-layer path is a one-cycle pass-through
  a_r9_dll_pass: assert property (@(posedge clk) disable iff (rst)
    !sel_os_i |=> tx_data_o == $past(dll_data_i) && tx_ctrl_o == $past(dll_ctrl_i));
  // R11: disabled lane emits PAD in its lane field
  a_r11_lane_pad: assert property (@(posedge clk) disable iff (rst)
    sel_os_i && lane_off_i && ts_now && cur_pos == PW'(LANE_POS)
      |=> tx_ctrl_o && tx_data_o == SYM_PAD);
  // R12: SKP symbols from the generator are never rewritten
  a_r12_skp_kept: assert property (@(posedge clk) disable iff (rst)
    sel_os_i && os_skp |=> tx_ctrl_o && tx_data_o == SYM_SKP);
endmodule

// File: rtl/lane_os_mac.sv
module lane_os_mac
  import lane_os_pkg::*;
#(
  parameter int SET_LEN = 16,
  parameter int CNT_W   = 4,
  parameter int LANE_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_ctrl,
  output logic              ts_done,
  output logic              ts_bad,
  output logic [1:0]        ts_type,
  output logic [CNT_W-1:0]  ts_count,
  input  logic              tx_sel_os,
  input  logic              tx_lane_off,
  input  logic [LANE_W-1:0] lane_num,
  input  logic [7:0]        os_data,
  input  logic              os_ctrl,
  input  logic [7:0]        dll_data,
  input  logic              dll_ctrl,
  output logic [7:0]        tx_data,
  output logic              tx_ctrl
);
  logic     p_done, p_bad;
  ts_kind_e p_kind, r_kind;

  lm_rx_parse #(.SET_LEN(SET_LEN)) u_parse (
    .clk(clk), .rst(rst), .valid_i(rx_valid), .data_i(rx_data), .ctrl_i(rx_ctrl),
    .done_o(p_done), .bad_o(p_bad), .kind_o(p_kind)
  );

  lm_rx_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .done_i(p_done), .bad_i(p_bad), .kind_i(p_kind),
    .done_o(ts_done), .bad_o(ts_bad), .kind_o(r_kind), .cnt_o(ts_count)
  );

  assign ts_type = r_kind;

  lm_tx_patch #(.SET_LEN(SET_LEN), .LANE_W(LANE_W)) u_tx (
    .clk(clk), .rst(rst), .sel_os_i(tx_sel_os), .lane_off_i(tx_lane_off),
    .lane_num_i(lane_num), .os_data_i(os_data), .os_ctrl_i(os_ctrl),
    .dll_data_i(dll_data), .dll_ctrl_i(dll_ctrl),
    .tx_data_o(tx_data), .tx_ctrl_o(tx_ctrl)
  );
endmodule

// File: tb/sim_lane_os_mac.sv
`timescale 1ns/1ps
module sim_lane_os_mac;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0, rx_ctrl = 1'b0;
  logic [7:0] rx_data = '0;
  logic ts_done, ts_bad;
  logic [1:0] ts_type;
  logic [3:0] ts_count;
  logic tx_sel_os = 1'b0, tx_lane_off = 1'b0, os_ctrl = 1'b0, dll_ctrl = 1'b0;
  logic [4:0] lane_num = 5'd3;
  logic [7:0] os_data = '0, dll_data = '0;
  logic [7:0] tx_data;
  logic tx_ctrl;

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #10 clk = ~clk;

  lane_os_mac u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ctrl(rx_ctrl),
    .ts_done(ts_done), .ts_bad(ts_bad), .ts_type(ts_type), .ts_count(ts_count),
    .tx_sel_os(tx_sel_os), .tx_lane_off(tx_lane_off), .lane_num(lane_num),
    .os_data(os_data), .os_ctrl(os_ctrl), .dll_data(dll_data), .dll_ctrl(dll_ctrl),
    .tx_data(tx_data), .tx_ctrl(tx_ctrl)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // one symbol: drive at falling edge, return just after the capturing edge
  task automatic rx_sym(input logic [7:0] d, input logic c, input logic v);
    @(negedge clk);
    rx_data = d; rx_ctrl = c; rx_valid = v;
    @(posedge clk); #1;
  endtask

  function automatic logic [8:0] ts_sym(input int i, input logic [7:0] id, input bit pad);
    case (i)
      0: return {1'b1, 8'hBC};
      1: return pad ? {1'b1, 8'hF7} : {1'b0, 8'h01};
      2: return pad ? {1'b1, 8'hF7} : {1'b0, 8'h02};
      3: return {1'b0, 8'h10};
      4: return {1'b0, 8'h02};
      5: return {1'b0, 8'h00};
      default: return {1'b0, id};
    endcase
  endfunction

  task automatic send_ts(input logic [7:0] id, input bit pad, input bit gap);
    for (int i = 0; i < 16; i++) begin
      logic [8:0] s;
      if (gap && i == 8) begin
        for (int g = 0; g < 3; g++) begin
          rx_sym(8'hBC, 1'b1, 1'b0);
          chk("R8 no done in gap", ts_done, 0);
        end
      end
      s = ts_sym(i, id, pad);
      rx_sym(s[7:0], s[8], 1'b1);
    end
  endtask

  task automatic send_prefix(input logic [7:0] id, input int n);
    for (int i = 0; i < n; i++) begin
      logic [8:0] s;
      s = ts_sym(i, id, 1'b0);
      rx_sym(s[7:0], s[8], 1'b1);
    end
  endtask

  task automatic expect_rx(input string req, input int done, input int bad, input int typ, input int cnt);
    chk({req, " ts_done"}, ts_done, done);
    chk({req, " ts_bad"}, ts_bad, bad);
    chk({req, " ts_type"}, ts_type, typ);
    chk({req, " ts_count"}, ts_count, cnt);
  endtask

  task automatic tx_step(input logic sel, input logic off, input logic [7:0] od, input logic oc,
                         input logic [7:0] dd, input logic dc, input logic [7:0] ed, input logic ec,
                         input string req);
    @(negedge clk);
    tx_sel_os = sel; tx_lane_off = off; os_data = od; os_ctrl = oc; dll_data = dd; dll_ctrl = dc;
    @(posedge clk); #1;
    chk({req, " tx_data"}, tx_data, ed);
    chk({req, " tx_ctrl"}, tx_ctrl, ec);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    expect_rx("R1 reset", 0, 0, 0, 0);
    chk("R1 reset tx_data", tx_data, 0);
    chk("R1 reset tx_ctrl", tx_ctrl, 0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_run_one();
    for (int k = 1; k <= 3; k++) begin
      send_ts(8'h4A, 1'b0, 1'b0);
      expect_rx("R2 R3 type-one run", 1, 0, 1, k);
    end
    rx_sym(8'h00, 1'b0, 1'b0);
    chk("R2 done is one cycle", ts_done, 0);
  endtask

  task automatic t_type_change();
    send_ts(8'h45, 1'b0, 1'b0);
    expect_rx("R4 switch to type two", 1, 0, 2, 1);
    send_ts(8'h45, 1'b0, 1'b0);
    expect_rx("R3 type two again", 1, 0, 2, 2);
  endtask

  task automatic t_saturate();
    for (int k = 1; k <= 17; k++) begin
      send_ts(8'h4A, 1'b0, 1'b0);
      if (k == 1)  expect_rx("R4 back to type one", 1, 0, 1, 1);
      if (k == 15) expect_rx("R5 reach ceiling", 1, 0, 1, 15);
      if (k == 17) expect_rx("R5 hold ceiling", 1, 0, 1, 15);
    end
  endtask

  task automatic t_malformed();
    send_prefix(8'h4A, 9);
    rx_sym(8'h7C, 1'b1, 1'b1);
    expect_rx("R6 control at index 9", 0, 1, 0, 0);
    send_prefix(8'h4A, 6);
    rx_sym(8'h11, 1'b0, 1'b1);
    expect_rx("R6 unknown identifier", 0, 1, 0, 0);
    send_prefix(8'h4A, 1);
    rx_sym(8'h1C, 1'b1, 1'b1);
    expect_rx("R6 non-PAD control in link field", 0, 1, 0, 0);
    send_prefix(8'h4A, 10);
    rx_sym(8'hBC, 1'b1, 1'b1);
    expect_rx("R6 COM mid-set", 0, 1, 0, 0);
    for (int i = 1; i < 16; i++) begin
      logic [8:0] s;
      s = ts_sym(i, 8'h4A, 1'b0);
      rx_sym(s[7:0], s[8], 1'b1);
    end
    expect_rx("R6 restart at COM", 1, 0, 1, 1);
  endtask

  task automatic t_pad_and_gap();
    send_ts(8'h4A, 1'b1, 1'b0);
    expect_rx("R7 PAD fields accepted", 1, 0, 1, 2);
    send_ts(8'h4A, 1'b0, 1'b1);
    expect_rx("R8 gaps ignored", 1, 0, 1, 3);
  endtask

  task automatic t_tx_dll();
    tx_step(1'b0, 1'b0, 8'hAA, 1'b1, 8'h3C, 1'b0, 8'h3C, 1'b0, "R9 link data");
    tx_step(1'b0, 1'b0, 8'hBC, 1'b1, 8'hFB, 1'b1, 8'hFB, 1'b1, "R9 link control");
  endtask

  task automatic t_tx_ts();
    tx_step(1'b1, 1'b0, 8'hBC, 1'b1, 8'h00, 1'b0, 8'hBC, 1'b1, "R10 COM");
    tx_step(1'b1, 1'b0, 8'h07, 1'b0, 8'h00, 1'b0, 8'h07, 1'b0, "R10 link kept");
    tx_step(1'b1, 1'b0, 8'hF7, 1'b1, 8'h00, 1'b0, 8'h03, 1'b0, "R10 lane number");
    tx_step(1'b1, 1'b0, 8'h10, 1'b0, 8'h00, 1'b0, 8'h10, 1'b0, "R10 index 3 kept");
    lane_num = 5'd17;
    tx_step(1'b1, 1'b0, 8'hBC, 1'b1, 8'h00, 1'b0, 8'hBC, 1'b1, "R10 COM 2");
    tx_step(1'b1, 1'b0, 8'h07, 1'b0, 8'h00, 1'b0, 8'h07, 1'b0, "R10 link kept 2");
    tx_step(1'b1, 1'b0, 8'hF7, 1'b1, 8'h00, 1'b0, 8'h11, 1'b0, "R10 lane 17");
  endtask

  task automatic t_tx_off();
    tx_step(1'b1, 1'b1, 8'hBC, 1'b1, 8'h00, 1'b0, 8'hBC, 1'b1, "R11 COM");
    tx_step(1'b1, 1'b1, 8'h07, 1'b0, 8'h00, 1'b0, 8'hF7, 1'b1, "R11 link PAD");
    tx_step(1'b1, 1'b1, 8'h00, 1'b0, 8'h00, 1'b0, 8'hF7, 1'b1, "R11 lane PAD");
    tx_step(1'b1, 1'b1, 8'h4A, 1'b0, 8'h00, 1'b0, 8'h4A, 1'b0, "R11 id kept");
  endtask

  task automatic t_tx_skp();
    tx_step(1'b1, 1'b0, 8'hBC, 1'b1, 8'h00, 1'b0, 8'hBC, 1'b1, "R12 COM");
    for (int i = 1; i < 4; i++)
      tx_step(1'b1, 1'b0, 8'h1C, 1'b1, 8'h00, 1'b0, 8'h1C, 1'b1, "R12 SKP kept");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    t_reset();
    t_run_one();
    t_type_change();
    t_saturate();
    t_malformed();
    t_pad_and_gap();
    t_tx_dll();
    t_tx_ts();
    t_tx_off();
    t_tx_skp();
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule